// File: doc/BRIEF.md
# Big-Endian Byte-Lane Load/Store Unit

This unit sits between a 32-bit core and a data memory that is one word wide and addressed by byte. For a store, it takes a byte address, an access size and the register value. It returns a word address, a byte-lane write mask and write data with each lane already in place, all registered one cycle after the request. For a load, it issues the word read. When the memory returns the word one cycle later, it picks out the addressed byte, halfword or word and widens it to a full 32-bit register value. A per-request flag selects sign extension or zero extension.

Byte numbering is big-endian: the byte whose address has low bits 00 is the most significant byte of the word. An access whose address is not a multiple of its size is never split into two transfers. It is dropped, and the unit raises an alignment error for the cycle in which the access would otherwise have been issued. The unit assumes a memory with a fixed read latency of one cycle.

Top module: `be_lsu`

## Requirements
- R1: While reset is asserted, and until the first request after reset, `mem_vld`, `mem_we`, `mem_be`, `align_err` and `ld_vld` are all low.
- R2: A request is registered, and its memory-side outputs appear in the following cycle. `mem_waddr` is the byte address shifted right by two. For a byte store (size code 00) at offset k = addr[1:0], only `mem_be` bit 3-k is set, and the store byte is copied into all four lanes of `mem_wdata`. Lane i is bits 8i+7:8i.
- R3: A halfword store (size code 01) at offset 0 sets `mem_be` to 1100. At offset 2 it sets `mem_be` to 0011. The 16-bit value appears in both the upper and the lower half of `mem_wdata`.
- R4: A word store (size code 10) at offset 0 sets `mem_be` to 1111 and passes the 32-bit value through unchanged.
- R5: The following accesses are misaligned: a halfword with addr[0]=1, and a word with addr[1:0] not equal to 00. For a misaligned access, `align_err` is high for exactly the one cycle after the request, `mem_vld` stays low and `mem_be` is 0000. Memory content is therefore unchanged, and a misaligned load produces no `ld_vld`.
- R6: The size code 11 is reserved and is handled exactly like a misaligned access.
- R7: An aligned load drives `mem_vld` high, `mem_we` low and `mem_be` to 0000 in the cycle after the request.
- R8: A signed load (`req_uns`=0) of a byte or halfword copies the top bit of the selected item into every upper bit of `ld_data`. The byte at offset k is taken from lane 3-k. The halfword at offset 0 is taken from lanes 3:2, and at offset 2 from lanes 1:0. `ld_vld` and `ld_data` appear one cycle after `mem_rvld`.
- R9: An unsigned byte or halfword load (`req_uns`=1) fills all upper bits of `ld_data` with zeros.
- R10: A word load returns the memory word unchanged, whatever the value of `req_uns`.
- R11: `req_uns` has no effect on stores.
- R12: Requests may be back to back. A load's offset, size and sign mode are kept until its data returns. A load return and the issue or rejection of a later request can occur in the same cycle without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_vld | input | 1 | Request present this cycle |
| req_we | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_uns | input | 1 | Zero-extend a narrow load (loads only) |
| req_wdata | input | 32 | Store value, right-justified |
| mem_rvld | input | 1 | Read word valid, one cycle after a load issue |
| mem_rdata | input | 32 | Read word from memory |
| mem_vld | output | 1 | Memory access issued |
| mem_we | output | 1 | Issued access is a write |
| mem_waddr | output | ADDR_W-2 | Word address |
| mem_be | output | 4 | Byte-lane write enables, bit i = lane i |
| mem_wdata | output | 32 | Lane-aligned write data |
| align_err | output | 1 | Misaligned or reserved-size request, one-cycle flag |
| ld_vld | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Two functions can be active in the same cycle: the return path of an earlier load, which drives `ld_vld` and `ld_data`, and the request path of a later access, which drives `mem_vld`, `mem_be` or `align_err`. The bench provokes this overlap in two ways. It issues a load, waits one idle cycle and then sends a misaligned store, so that the alignment error and the load result land together. It also sends two loads with different sizes and sign modes back to back. In each case it checks, in the same sampled cycle, that the loaded value matches the first request's size and sign mode, and that the second request's outputs are exactly what that request alone would produce.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  parameter int DATA_W = 32;
  parameter int LANE_W = 8;
  localparam int LANES = DATA_W / LANE_W;
  localparam int OFF_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef struct packed {
    logic [OFF_W-1:0] off;
    acc_size_e        size;
    logic             uns;
  } ld_ctx_t;
endpackage

// File: rtl/lsu_align_chk.sv
module lsu_align_chk
  import lsu_pkg::*;
(
  input  logic [OFF_W-1:0] addr_lo,
  input  acc_size_e        size,
  output logic             bad
);
  always_comb begin
    unique case (size)
      SZ_BYTE: bad = 1'b0;
      SZ_HALF: bad = addr_lo[0];
      SZ_WORD: bad = |addr_lo;
      default: bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
(
  input  logic [OFF_W-1:0]  off,
  input  acc_size_e         size,
  input  logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_data
);
  logic [OFF_W-1:0] tgt;
  assign tgt = OFF_W'(LANES - 1) - off;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [OFF_W-1:0] idx;
    assign idx = OFF_W'(i);

    always_comb begin
      unique case (size)
        SZ_BYTE: be[i] = (idx == tgt);
        SZ_HALF: be[i] = ((idx >> 1) == (tgt >> 1));
        SZ_WORD: be[i] = 1'b1;
        default: be[i] = 1'b0;
      endcase
    end

    always_comb begin
      unique case (size)
        SZ_BYTE: lane_data[i*LANE_W +: LANE_W] = data[LANE_W-1:0];
        SZ_HALF: lane_data[i*LANE_W +: LANE_W] = data[(i%2)*LANE_W +: LANE_W];
        default: lane_data[i*LANE_W +: LANE_W] = data[i*LANE_W +: LANE_W];
      endcase
    end
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  logic [DATA_W-1:0] word,
  input  ld_ctx_t           ctx,
  output logic [DATA_W-1:0] result
);
  localparam int HALF_W = 2 * LANE_W;

  logic [DATA_W-1:0] shifted;
  logic [LANE_W-1:0] sel_b;
  logic [HALF_W-1:0] sel_h;

  assign shifted = word << {ctx.off, 3'b000};
  assign sel_b   = shifted[DATA_W-1 -: LANE_W];
  assign sel_h   = shifted[DATA_W-1 -: HALF_W];

  always_comb begin
    unique case (ctx.size)
      SZ_BYTE: result = {{(DATA_W-LANE_W){~ctx.uns & sel_b[LANE_W-1]}}, sel_b};
      SZ_HALF: result = {{(DATA_W-HALF_W){~ctx.uns & sel_h[HALF_W-1]}}, sel_h};
      default: result = word;
    endcase
  end
endmodule

// File: rtl/be_lsu.sv
module be_lsu
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_vld,
  input  logic                    req_we,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [1:0]              req_size,
  input  logic                    req_uns,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic                    mem_rvld,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    mem_vld,
  output logic                    mem_we,
  output logic [ADDR_W-OFF_W-1:0] mem_waddr,
  output logic [LANES-1:0]        mem_be,
  output logic [DATA_W-1:0]       mem_wdata,
  output logic                    align_err,
  output logic                    ld_vld,
  output logic [DATA_W-1:0]       ld_data
);
  localparam int WADDR_W = ADDR_W - OFF_W;

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ok = rst_sync_q[1];

  // request decode
  acc_size_e         size_in;
  logic              misal;
  logic [LANES-1:0]  lane_be;
  logic [DATA_W-1:0] lane_data;
  ld_ctx_t           ctx_in;

  assign size_in = acc_size_e'(req_size);
  assign ctx_in  = '{off: req_addr[OFF_W-1:0], size: size_in, uns: req_uns};

  lsu_align_chk u_align (
    .addr_lo (req_addr[OFF_W-1:0]),
    .size    (size_in),
    .bad     (misal)
  );

  lsu_store_lane u_lane (
    .off       (req_addr[OFF_W-1:0]),
    .size      (size_in),
    .data      (req_wdata),
    .be        (lane_be),
    .lane_data (lane_data)
  );

  // issue stage next state
  logic             issue_nxt;
  logic             err_nxt;
  logic [LANES-1:0] be_nxt;

  always_comb begin
    issue_nxt = req_vld & ~misal;
    err_nxt   = req_vld & misal;
    be_nxt    = (issue_nxt & req_we) ? lane_be : '0;
  end

  // issue stage registers
  logic               vld_q, we_q, err_q;
  logic [LANES-1:0]   be_q;
  logic [WADDR_W-1:0] waddr_q;
  logic [DATA_W-1:0]  wdata_q;
  ld_ctx_t            ctx1_q;

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      vld_q <= 1'b0;
      we_q  <= 1'b0;
      err_q <= 1'b0;
      be_q  <= '0;
    end else begin
      vld_q <= issue_nxt;
      err_q <= err_nxt;
      be_q  <= be_nxt;
      if (req_vld) we_q <= req_we;
    end
  end

  always_ff @(posedge clk) begin
    if (req_vld) begin
      waddr_q <= req_addr[ADDR_W-1:OFF_W];
      wdata_q <= lane_data;
      ctx1_q  <= ctx_in;
    end
  end

  // load context, held from issue until data returns
  logic    ld_issue;
  ld_ctx_t ctx2_q;

  assign ld_issue = vld_q & ~we_q;

  always_ff @(posedge clk) begin
    if (ld_issue) ctx2_q <= ctx1_q;
  end

  // load return stage
  logic [DATA_W-1:0] ext_data;
  logic              ldv_q;
  logic [DATA_W-1:0] ldd_q;

  lsu_load_extract u_ext (
    .word   (mem_rdata),
    .ctx    (ctx2_q),
    .result (ext_data)
  );

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) ldv_q <= 1'b0;
    else         ldv_q <= mem_rvld;
  end

  always_ff @(posedge clk) begin
    if (mem_rvld) ldd_q <= ext_data;
  end

  assign mem_vld   = vld_q;
  assign mem_we    = we_q & vld_q;
  assign mem_waddr = waddr_q;
  assign mem_be    = be_q;
  assign mem_wdata = wdata_q;
  assign align_err = err_q;
  assign ld_vld    = ldv_q;
  assign ld_data   = ldd_q;
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker
  import lsu_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             req_vld,
  input logic [1:0]       req_size,
  input logic             mem_vld,
  input logic             mem_we,
  input logic [LANES-1:0] mem_be,
  input logic             align_err,
  input logic             mem_rvld,
  input logic             ld_vld
);
  // R5: a rejected access never issues and never enables a lane
  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> (!mem_vld && mem_be == '0));

  // R2: byte stores enable exactly one lane
  p_byte_one_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld && mem_we && $past(req_size) == 2'b00) |-> ($countones(mem_be) == 1));

  // R3: halfword stores enable an aligned lane pair
  p_half_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld && mem_we && $past(req_size) == 2'b01) |-> (mem_be == 4'b1100 || mem_be == 4'b0011));

  // R7: loads never enable a write lane
  p_load_no_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld && !mem_we) |-> (mem_be == '0));

  // R8: a load result follows a read return by one cycle
  p_ld_after_ret_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ld_vld |-> $past(mem_rvld));

  // R12: any issue or rejection traces back to a request
  p_issue_from_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_vld || align_err) |-> $past(req_vld));
endmodule

bind be_lsu lsu_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_vld   (req_vld),
  .req_size  (req_size),
  .mem_vld   (mem_vld),
  .mem_we    (mem_we),
  .mem_be    (mem_be),
  .align_err (align_err),
  .mem_rvld  (mem_rvld),
  .ld_vld    (ld_vld)
);

// File: tb/sim_be_lsu.sv
`timescale 1ns/1ps
module sim_be_lsu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_vld, req_we, req_uns;
  logic [31:0] req_addr, req_wdata;
  logic [1:0]  req_size;
  logic        mem_rvld;
  logic [31:0] mem_rdata;
  logic        mem_vld, mem_we, align_err, ld_vld;
  logic [29:0] mem_waddr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata, ld_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  be_lsu u0 (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_we(req_we),
    .req_addr(req_addr), .req_size(req_size), .req_uns(req_uns),
    .req_wdata(req_wdata), .mem_rvld(mem_rvld), .mem_rdata(mem_rdata),
    .mem_vld(mem_vld), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .align_err(align_err),
    .ld_vld(ld_vld), .ld_data(ld_data)
  );

  // memory model: one-cycle read latency
  logic [31:0] bmem [0:7];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvld <= 1'b0;
    end else begin
      mem_rvld  <= mem_vld && !mem_we;
      mem_rdata <= bmem[mem_waddr[2:0]];
      if (mem_vld && mem_we)
        for (int b = 0; b < 4; b++)
          if (mem_be[b]) bmem[mem_waddr[2:0]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_vld = 1'b0; req_we = 1'b0; req_uns = 1'b0;
    req_addr = '0; req_size = 2'b00; req_wdata = '0;
  endtask

  task automatic drive(logic we, logic [31:0] a, logic [1:0] sz, logic u, logic [31:0] d);
    req_vld = 1'b1; req_we = we; req_addr = a; req_size = sz; req_uns = u; req_wdata = d;
  endtask

  task automatic t_store(string tag, logic [31:0] a, logic [1:0] sz, logic u,
                         logic [31:0] d, logic [3:0] ebe, logic [31:0] ewd);
    @(negedge clk); drive(1'b1, a, sz, u, d);
    @(negedge clk);
    chk({tag, " vld"},   {31'd0, mem_vld},   32'd1);
    chk({tag, " we"},    {31'd0, mem_we},    32'd1);
    chk({tag, " waddr"}, {2'b00, mem_waddr}, a >> 2);
    chk({tag, " be"},    {28'd0, mem_be},    {28'd0, ebe});
    chk({tag, " wdata"}, mem_wdata, ewd);
    chk({tag, " err"},   {31'd0, align_err}, 32'd0);
    idle();
  endtask

  task automatic t_reject(string tag, logic we, logic [31:0] a, logic [1:0] sz);
    @(negedge clk); drive(we, a, sz, 1'b0, 32'h0000_0000);
    @(negedge clk);
    chk({tag, " err"}, {31'd0, align_err}, 32'd1);
    chk({tag, " vld"}, {31'd0, mem_vld},   32'd0);
    chk({tag, " be"},  {28'd0, mem_be},    32'd0);
    idle();
    @(negedge clk);
    chk({tag, " err one cycle"}, {31'd0, align_err}, 32'd0);
    @(negedge clk);
    chk({tag, " no ld"}, {31'd0, ld_vld}, 32'd0);
  endtask

  task automatic t_load(string tag, logic [31:0] a, logic [1:0] sz, logic u, logic [31:0] exp);
    @(negedge clk); drive(1'b0, a, sz, u, 32'hDEAD_BEEF);
    @(negedge clk);
    chk({tag, " R7 vld"}, {31'd0, mem_vld}, 32'd1);
    chk({tag, " R7 we"},  {31'd0, mem_we},  32'd0);
    chk({tag, " R7 be"},  {28'd0, mem_be},  32'd0);
    idle();
    @(negedge clk);
    @(negedge clk);
    chk({tag, " ldv"},  {31'd0, ld_vld}, 32'd1);
    chk({tag, " data"}, ld_data, exp);
  endtask

  // R12: load return coincides with a rejected store
  task automatic t_overlap_reject();
    @(negedge clk); drive(1'b0, 32'h0000_0006, 2'b00, 1'b0, '0);
    @(negedge clk); idle();
    @(negedge clk); drive(1'b1, 32'h0000_0005, 2'b10, 1'b0, 32'h1111_1111);
    @(negedge clk);
    chk("R12 ovl ldv",  {31'd0, ld_vld},    32'd1);
    chk("R12 ovl data", ld_data, 32'hFFFF_FF84);
    chk("R12 ovl err",  {31'd0, align_err}, 32'd1);
    chk("R12 ovl vld",  {31'd0, mem_vld},   32'd0);
    idle();
  endtask

  // R12: back-to-back loads with different size and sign mode
  task automatic t_b2b_loads();
    @(negedge clk); drive(1'b0, 32'h0000_0004, 2'b01, 1'b0, '0);
    @(negedge clk); drive(1'b0, 32'h0000_0006, 2'b00, 1'b1, '0);
    @(negedge clk); idle();
    @(negedge clk);
    chk("R12 b2b first ldv",  {31'd0, ld_vld}, 32'd1);
    chk("R12 b2b first",      ld_data, 32'hFFFF_F123);
    @(negedge clk);
    chk("R12 b2b second ldv", {31'd0, ld_vld}, 32'd1);
    chk("R12 b2b second",     ld_data, 32'h0000_0084);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 8; i++) bmem[i] = 32'h0000_0000;
    bmem[1] = 32'hF123_8456;
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 vld", {31'd0, mem_vld},   32'd0);
    chk("R1 we",  {31'd0, mem_we},    32'd0);
    chk("R1 be",  {28'd0, mem_be},    32'd0);
    chk("R1 err", {31'd0, align_err}, 32'd0);
    chk("R1 ldv", {31'd0, ld_vld},    32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release", {29'd0, mem_vld, align_err, ld_vld}, 32'd0);

    // loads from word 1 = F1 23 84 56 (big-endian bytes 4..7)
    t_load("R8 lb off0",  32'h4, 2'b00, 1'b0, 32'hFFFF_FFF1);
    t_load("R9 lbu off0", 32'h4, 2'b00, 1'b1, 32'h0000_00F1);
    t_load("R8 lb off1",  32'h5, 2'b00, 1'b0, 32'h0000_0023);
    t_load("R8 lb off2",  32'h6, 2'b00, 1'b0, 32'hFFFF_FF84);
    t_load("R8 lb off3",  32'h7, 2'b00, 1'b0, 32'h0000_0056);
    t_load("R8 lh off0",  32'h4, 2'b01, 1'b0, 32'hFFFF_F123);
    t_load("R8 lh off2",  32'h6, 2'b01, 1'b0, 32'hFFFF_8456);
    t_load("R9 lhu off2", 32'h6, 2'b01, 1'b1, 32'h0000_8456);
    t_load("R10 lw s",    32'h4, 2'b10, 1'b0, 32'hF123_8456);
    t_load("R10 lw u",    32'h4, 2'b10, 1'b1, 32'hF123_8456);

    // stores
    t_store("R2 sb off1",  32'h9,  2'b00, 1'b0, 32'hABCD_EF5A, 4'b0100, 32'h5A5A_5A5A);
    t_store("R2 sb off3",  32'hB,  2'b00, 1'b0, 32'h0000_00C3, 4'b0001, 32'hC3C3_C3C3);
    t_load ("R2 sb lanes", 32'h8,  2'b10, 1'b0, 32'h005A_00C3);
    t_store("R3 sh off0",  32'hC,  2'b01, 1'b0, 32'h0000_7788, 4'b1100, 32'h7788_7788);
    t_store("R11 sh off2 uns", 32'hE, 2'b01, 1'b1, 32'h1234_BEEF, 4'b0011, 32'hBEEF_BEEF);
    t_load ("R3 sh lanes", 32'hC,  2'b10, 1'b0, 32'h7788_BEEF);
    t_store("R4 sw",       32'h10, 2'b10, 1'b0, 32'hCAFE_F00D, 4'b1111, 32'hCAFE_F00D);

    // rejected accesses
    t_reject("R5 sh odd",   1'b1, 32'hD,  2'b01);
    t_reject("R5 sw off2",  1'b1, 32'hE,  2'b10);
    t_reject("R5 sw off1",  1'b1, 32'h11, 2'b10);
    t_reject("R6 rsvd st",  1'b1, 32'h10, 2'b11);
    t_reject("R5 lh odd",   1'b0, 32'h5,  2'b01);
    t_reject("R6 rsvd ld",  1'b0, 32'h4,  2'b11);
    t_load  ("R5 mem kept 3", 32'hC,  2'b10, 1'b0, 32'h7788_BEEF);
    t_load  ("R6 mem kept 4", 32'h10, 2'b10, 1'b0, 32'hCAFE_F00D);

    // overlap
    t_overlap_reject();
    t_b2b_loads();

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule